// File: doc/BRIEF.md
# Mixed-Width Down-Counting Timer Set

This block holds four timers behind a small word-addressed register bus. Three of them are reloading down-counters: two are 16 bits wide and one is 32 bits wide. Each counts on a tick enable chosen by its control register, either the slow tick or the fast tick. When a counter steps past zero it raises its own interrupt level, which stays high until software writes that timer's clear register. A counter then either reloads from its load register (periodic mode) or wraps to all ones (free-running mode).

The fourth timer is a 40-bit up-counter that advances on the fast tick. It is meant as a timestamp. It never interrupts. Software enables it with one bit in its upper register and reads its low 32 bits directly. Software normally brings a reloading timer up in three writes: a control value with the enable clear, then the load value, then the same control value with the enable set. A load value of L gives an interrupt every L+1 selected ticks. Both tick enables are inputs, one clock cycle wide per tick.

Top module: `quad_timer_bank`

## Requirements
- R1: After reset, every readable register reads zero and all three interrupt outputs are low.
- R2: Writing a control value with bit 7 (enable) set to a stopped timer copies its load register into its counter. While bit 7 is clear, the counter holds its value whatever ticks or load writes arrive.
- R3: In periodic mode (control bit 6 set), a timer whose counter starts at L raises its interrupt on exactly the (L+1)-th selected tick, and its counter then reads L again.
- R4: In free-running mode (control bit 6 clear), stepping past zero raises the interrupt and sets the counter to all ones of that timer's width.
- R5: An interrupt output stays high across further ticks until a write of any data to that timer's clear register, after which it reads low.
- R6: A clear write in the same cycle as an underflow leaves the interrupt high.
- R7: Control bit 3 set makes a timer count on slow_tick only. Bit 3 clear makes it count on fast_tick only. The unselected tick has no effect.
- R8: Timers 0 and 1 are 16 bits wide and timer 2 is 32 bits wide. Load writes keep only the low bits of that width, and counter and load reads are zero-extended.
- R9: The timestamp counts up by one per fast_tick while bit 8 of its upper register is set, and holds while that bit is clear. It ignores slow_tick. Its upper register reads the enable in bit 8 and counter bits 39:32 in bits 7:0. Counter bits cannot be written.
- R10: Word address 4t+0 is timer t's load, 4t+1 its counter (read only), 4t+2 its control (only bits 7, 6 and 3 are stored and read back), and 4t+3 its clear (reads zero). Address 12 is timestamp bits 31:0 and 13 is its upper register. Addresses 14 and 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow count enable, one cycle per tick |
| fast_tick | input | 1 | Fast count enable, one cycle per tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Underflow interrupt levels, one per reloading timer |

## Verification
A wrong counter or load state shows up on the value register read in the same cycle after the next tick. A wrong reload or wrap value also moves every later interrupt: the irq edge arrives too early or too late by a whole number of ticks. A lost or stuck interrupt flag is visible at the irq pin one cycle after the underflow or clear that should have changed it. The sweeps step each timer through every tick of several short periods, so an off-by-one in the period shows up within a single period.

// File: rtl/qtb_pkg.sv
package qtb_pkg;
  localparam int REG_PER_TMR = 4;
  localparam int OFS_LOAD    = 0;
  localparam int OFS_VALUE   = 1;
  localparam int OFS_CTRL    = 2;
  localparam int OFS_CLEAR   = 3;
  // control bit positions software depends on
  localparam int CB_EN       = 7;
  localparam int CB_PER      = 6;
  localparam int CB_SLOW     = 3;

  typedef struct packed {
    logic en;
    logic periodic;
    logic slow_sel;
  } tmr_ctl_t;
endpackage

// File: rtl/qtb_reload_timer.sv
module qtb_reload_timer
  import qtb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          fast_tick,
  input  logic          load_wr,
  input  logic          ctrl_wr,
  input  logic          clear_wr,
  input  logic [W-1:0]  load_data,
  input  tmr_ctl_t      ctrl_data,
  output logic [W-1:0]  count_o,
  output logic [W-1:0]  load_o,
  output tmr_ctl_t      ctrl_o,
  output logic          irq_o
);
  logic [W-1:0] cnt_q, cnt_d, load_q, load_d;
  tmr_ctl_t     ctl_q, ctl_d;
  logic         irq_q, irq_d;
  logic         start, step, wrap;

  always_comb begin
    start  = ctrl_wr && ctrl_data.en && !ctl_q.en;
    step   = ctl_q.en && (ctl_q.slow_sel ? slow_tick : fast_tick);
    wrap   = step && (cnt_q == '0);
    load_d = load_wr ? load_data : load_q;
    ctl_d  = ctrl_wr ? ctrl_data : ctl_q;
    cnt_d  = cnt_q;
    if (start)      cnt_d = load_q;
    else if (wrap)  cnt_d = ctl_q.periodic ? load_q : '1;
    else if (step)  cnt_d = cnt_q - W'(1);
    irq_d  = wrap | (irq_q & ~clear_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      ctl_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
      ctl_q  <= ctl_d;
      irq_q  <= irq_d;
    end
  end

  assign count_o = cnt_q;
  assign load_o  = load_q;
  assign ctrl_o  = ctl_q;
  assign irq_o   = irq_q;

  assert_hold_while_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !start) |=> $stable(cnt_q));
  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == $past(load_q)));
  assert_periodic_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ctl_q.periodic) |=> (cnt_q == $past(load_q)));
  assert_free_wraps_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ctl_q.periodic) |=> (&cnt_q));
  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clear_wr) |=> irq_q);
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && !wrap) |=> !irq_q);
  assert_clear_loses_to_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && wrap) |=> irq_q);
endmodule

// File: rtl/qtb_stamp_counter.sv
module qtb_stamp_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fast_tick,
  input  logic         en_wr,
  input  logic         en_data,
  output logic [W-1:0] count_o,
  output logic         en_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         en_q, en_d;

  always_comb begin
    en_d  = en_wr ? en_data : en_q;
    cnt_d = (en_q && fast_tick) ? cnt_q + W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign count_o = cnt_q;
  assign en_o    = en_q;

  assert_stamp_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && fast_tick) |=> (cnt_q == $past(cnt_q) + W'(1)));
  assert_stamp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_q && fast_tick) |=> $stable(cnt_q));
endmodule

// File: rtl/quad_timer_bank.sv
module quad_timer_bank
  import qtb_pkg::*;
#(
  parameter int SMALL_W = 16,
  parameter int WIDE_W  = 32,
  parameter int NUM_TMR = 3,
  parameter int STAMP_W = 40,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slow_tick,
  input  logic                fast_tick,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_TMR-1:0]  irq
);
  localparam int STAMP_LO = NUM_TMR * REG_PER_TMR;
  localparam int STAMP_HI = STAMP_LO + 1;
  localparam int HI_W     = STAMP_W - DATA_W;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  logic [DATA_W-1:0] cnt_rd  [NUM_TMR];
  logic [DATA_W-1:0] load_rd [NUM_TMR];
  logic [DATA_W-1:0] ctrl_rd [NUM_TMR];

  tmr_ctl_t ctl_in;
  assign ctl_in = '{en: bus_wdata[CB_EN], periodic: bus_wdata[CB_PER],
                    slow_sel: bus_wdata[CB_SLOW]};

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam int TW = (t == NUM_TMR - 1) ? WIDE_W : SMALL_W;
    logic [TW-1:0] cnt_w, load_w;
    tmr_ctl_t      ctl_w;
    logic          ld_hit, ctl_hit, clr_hit;

    assign ld_hit  = bus_wr && (bus_addr == ADDR_W'(t*REG_PER_TMR + OFS_LOAD));
    assign ctl_hit = bus_wr && (bus_addr == ADDR_W'(t*REG_PER_TMR + OFS_CTRL));
    assign clr_hit = bus_wr && (bus_addr == ADDR_W'(t*REG_PER_TMR + OFS_CLEAR));

    qtb_reload_timer #(.W(TW)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_int),
      .slow_tick (slow_tick),
      .fast_tick (fast_tick),
      .load_wr   (ld_hit),
      .ctrl_wr   (ctl_hit),
      .clear_wr  (clr_hit),
      .load_data (bus_wdata[TW-1:0]),
      .ctrl_data (ctl_in),
      .count_o   (cnt_w),
      .load_o    (load_w),
      .ctrl_o    (ctl_w),
      .irq_o     (irq[t])
    );

    assign cnt_rd[t]  = DATA_W'(cnt_w);
    assign load_rd[t] = DATA_W'(load_w);
    assign ctrl_rd[t] = (DATA_W'(ctl_w.en) << CB_EN) |
                        (DATA_W'(ctl_w.periodic) << CB_PER) |
                        (DATA_W'(ctl_w.slow_sel) << CB_SLOW);
  end

  logic [STAMP_W-1:0] stamp_cnt;
  logic               stamp_en;
  logic               stamp_hi_wr;
  assign stamp_hi_wr = bus_wr && (bus_addr == ADDR_W'(STAMP_HI));

  qtb_stamp_counter #(.W(STAMP_W)) u_stamp (
    .clk       (clk),
    .rst_n     (rst_int),
    .fast_tick (fast_tick),
    .en_wr     (stamp_hi_wr),
    .en_data   (bus_wdata[HI_W]),
    .count_o   (stamp_cnt),
    .en_o      (stamp_en)
  );

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (bus_addr == ADDR_W'(t*REG_PER_TMR + OFS_LOAD))  bus_rdata = load_rd[t];
      if (bus_addr == ADDR_W'(t*REG_PER_TMR + OFS_VALUE)) bus_rdata = cnt_rd[t];
      if (bus_addr == ADDR_W'(t*REG_PER_TMR + OFS_CTRL))  bus_rdata = ctrl_rd[t];
    end
    if (bus_addr == ADDR_W'(STAMP_LO)) bus_rdata = stamp_cnt[DATA_W-1:0];
    if (bus_addr == ADDR_W'(STAMP_HI)) begin
      bus_rdata[HI_W-1:0] = stamp_cnt[STAMP_W-1:DATA_W];
      bus_rdata[HI_W]     = stamp_en;
    end
  end
endmodule

// File: tb/quad_timer_bank_bench.sv
module quad_timer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n, slow_tick, fast_tick, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, v;
  logic [2:0]  irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  quad_timer_bank u_quad_timer_bank (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] wmask(int t);
    return (t == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a[3:0]; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = a[3:0]; #1; d = bus_rdata;
  endtask

  task automatic tick(bit fast, int n);
    repeat (n) begin
      @(negedge clk); if (fast) fast_tick = 1'b1; else slow_tick = 1'b1;
      @(negedge clk); fast_tick = 1'b0; slow_tick = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; slow_tick = 0; fast_tick = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin rd(a, v); chk("R1", v, 32'h0); end
    chk("R1 irq", {29'h0, irq}, 32'h0);

    // R3 / R2 / R5 period sweep on every timer
    for (int t = 0; t < 3; t++) begin
      for (int l = 0; l < 6; l++) begin
        wr(4*t+2, 32'h48); wr(4*t, l); wr(4*t+2, 32'hC8);
        rd(4*t+1, v); chk("R2 start load", v, l);
        for (int k = 1; k <= l; k++) begin
          tick(0, 1);
          rd(4*t+1, v); chk("R3 count", v, l - k);
          chk("R3 no early irq", {31'h0, irq[t]}, 32'h0);
        end
        tick(0, 1);
        chk("R3 irq at period", {31'h0, irq[t]}, 32'h1);
        rd(4*t+1, v); chk("R3 reload", v, l);
        tick(0, 1);
        chk("R5 irq sticky", {31'h0, irq[t]}, 32'h1);
        wr(4*t+3, 32'h5A);
        chk("R5 clear", {31'h0, irq[t]}, 32'h0);
      end
      wr(4*t+2, 32'h48);
    end

    // R6 clear and underflow together
    wr(0, 0); wr(2, 32'hC8);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 0; slow_tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; slow_tick = 1'b0;
    chk("R6 clear vs underflow", {31'h0, irq[0]}, 32'h1);
    wr(3, 0);
    chk("R6 plain clear", {31'h0, irq[0]}, 32'h0);
    wr(2, 32'h48);

    // R4 free-running wrap, 16 and 32 bits
    for (int t = 0; t < 3; t += 2) begin
      wr(4*t, 2); wr(4*t+2, 32'h88);
      tick(0, 2);
      rd(4*t+1, v); chk("R4 count", v, 0);
      chk("R4 no irq yet", {31'h0, irq[t]}, 32'h0);
      tick(0, 1);
      rd(4*t+1, v); chk("R4 wrap ones", v, wmask(t));
      chk("R4 irq", {31'h0, irq[t]}, 32'h1);
      tick(0, 1);
      rd(4*t+1, v); chk("R4 after wrap", v, wmask(t) - 1);
      wr(4*t+3, 0); wr(4*t+2, 32'h08);
    end

    // R7 clock select
    wr(4, 5); wr(6, 32'hC0);
    tick(0, 3);
    rd(5, v); chk("R7 slow ignored", v, 5);
    tick(1, 2);
    rd(5, v); chk("R7 fast counts", v, 3);
    wr(6, 32'hC8); wr(6, 32'h48); wr(6, 32'hC8);
    tick(1, 2);
    rd(5, v); chk("R7 fast ignored", v, 5);
    tick(0, 1);
    rd(5, v); chk("R7 slow counts", v, 4);

    // R2 hold while disabled
    wr(6, 32'h48);
    tick(0, 2); tick(1, 2); wr(4, 9);
    rd(5, v); chk("R2 hold", v, 4);
    rd(4, v); chk("R2 load stored", v, 9);

    // R8 widths
    wr(0, 32'h0001_2345); rd(0, v); chk("R8 16-bit load", v, 32'h2345);
    wr(8, 32'h8001_2345); rd(8, v); chk("R8 32-bit load", v, 32'h8001_2345);
    wr(10, 32'hC8); rd(9, v); chk("R8 32-bit count", v, 32'h8001_2345);
    wr(10, 32'h48);

    // R10 map details
    rd(14, v); chk("R10 hole 14", v, 0);
    rd(15, v); chk("R10 hole 15", v, 0);
    rd(3, v);  chk("R10 clear reads zero", v, 0);
    wr(6, 32'hFF); rd(6, v); chk("R10 ctrl bits", v, 32'hC8);
    wr(6, 32'h48); rd(6, v); chk("R10 ctrl off", v, 32'h48);

    // R9 timestamp
    rd(12, v); chk("R9 stamp idle", v, 0);
    tick(1, 3);
    rd(12, v); chk("R9 stamp disabled", v, 0);
    wr(13, 32'h1FF);
    rd(13, v); chk("R9 upper reg", v, 32'h100);
    tick(1, 7);
    rd(12, v); chk("R9 stamp counts", v, 7);
    tick(0, 3);
    rd(12, v); chk("R9 slow ignored", v, 7);
    wr(13, 0); tick(1, 4);
    rd(12, v); chk("R9 stamp hold", v, 7);
    rd(13, v); chk("R9 upper off", v, 0);
    chk("R9 no irq", {29'h0, irq}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule